// File: doc/BRIEF.md
# Two-Stage Clock Ratio Solver

This block turns a frequency request into register settings for a clock generator that has an optional pre-divider and a small post-divider. It receives a source frequency, a target frequency and a two-bit source index. It returns a pre-divider field, a post-divider field, and the frequency that those settings actually give. Each field holds its ratio minus one.

The solver first finds the smallest whole ratio that keeps the output at or below the target. For one chosen source index, ratios above a small limit are split between the two stages in fixed bands. For every other index, the post-divider carries the whole ratio. Ratios that neither stage can reach are cut to the stage limits, and a flag reports this.

A single iterative restoring divider, shared over time, does all the division. A request takes one start pulse and ends with a one-cycle done pulse. While a request is in progress, further start pulses are ignored.

Top module: `clkdiv_solver`

## Requirements
- R1: When the source rate is nonzero and the target exceeds it, the target is replaced by the source rate, giving both fields 0 and an achieved rate equal to the source rate.
- R2: The total ratio is the ceiling of source rate over the (clamped) target, so a target that does not divide the source evenly rounds the ratio up.
- R3: When the index is not 3, or the total ratio is 4 or less, the pre-divider field is 0 and the post-divider field is total ratio minus 1.
- R4: For index 3 and a total ratio from 5 to 31, the pre-ratio equals the total ratio and the post-ratio is 1 (post field 0).
- R5: For index 3, a total ratio from 32 to 63 gives post-ratio 2 and pre-ratio ceil(total/2); from 64 to 95 it gives post-ratio 3 and pre-ratio ceil(total/3).
- R6: For index 3, a total ratio of 96 or more gives post-ratio 4 and pre-ratio ceil(total/4).
- R7: The achieved rate is floor(floor(source / pre-ratio) / post-ratio).
- R8: The post-ratio is capped at 4 and the pre-ratio at 32. `sat` is 1 after a result in which either cap was applied, and 0 otherwise. The achieved rate uses the capped ratios.
- R9: A target of 0 ends with `done` and `err` = 1 and `sat` = 0, and leaves both fields and the achieved rate unchanged.
- R10: `done` is high for exactly one cycle per accepted start. `busy` is high while a request is in progress. A start while busy is ignored. The outputs change only in the cycle in which `done` is high.
- R11: A start raised in the cycle in which `done` is high is accepted as a new request.
- R12: A source rate of 0 with a nonzero target gives a total ratio of 1, both fields 0 and an achieved rate of 0, without error.
- R13: After reset, all fields, the achieved rate, `busy`, `done`, `err` and `sat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted when not busy |
| src_rate | input | RATE_W | Source frequency |
| tgt_rate | input | RATE_W | Target frequency |
| src_idx | input | 2 | Source index, value 3 enables splitting |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had a zero target |
| sat | output | 1 | Last result hit a ratio cap |
| pre_field | output | PRE_W | Pre-divider ratio minus one |
| post_field | output | POST_W | Post-divider ratio minus one |
| got_rate | output | RATE_W | Achieved output frequency |

## Verification
Two events can fall in the same cycle: the completion of one request and the start of the next. The bench raises start in the exact cycle in which done is observed. It then expects that second request to finish with its own results, and the first result must still be correct. The bench also raises start midway through a request that is running. It expects no extra done pulse, and it expects the running request's outputs to be unaffected.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ERR,
      ST_TOT,
      ST_PRE,
      ST_RT1,
      ST_RT2
   } solve_st_e;
endpackage

// File: rtl/clkdiv_divu.sv
// Iterative restoring divider: one quotient bit per cycle.
module clkdiv_divu #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem,
   output logic         fin
);
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] cnt;
   logic [W:0]    trial;
   logic [W:0]    diff;

   assign trial = {rem, quo[W-1]};
   assign diff  = trial - {1'b0, den};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo <= '0;
         rem <= '0;
         cnt <= '0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            quo <= num;
            rem <= '0;
            cnt <= CW'(W);
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            rem <= diff[W] ? trial[W-1:0] : diff[W-1:0];
            quo <= {quo[W-2:0], ~diff[W]};
            if (cnt == CW'(1)) fin <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/clkdiv_split.sv
// Band selection: post-ratio grows by one per PRE_MAX span of the total ratio.
module clkdiv_split #(
   parameter int W           = 32,
   parameter int PRE_MAX     = 32,
   parameter int POST_MAX    = 4,
   parameter int SPLIT_SEL   = 3,
   parameter int SPLIT_ABOVE = 4
) (
   input  logic [W-1:0] ratio,
   input  logic [1:0]   sel,
   output logic         split_en,
   output logic [W-1:0] band
);
   logic [POST_MAX-1:0] over;

   assign over[0] = 1'b0;
   for (genvar b = 1; b < POST_MAX; b++) begin : g_band
      assign over[b] = (ratio >= W'(b * PRE_MAX));
   end

   assign split_en = (sel == 2'(SPLIT_SEL)) && (ratio > W'(SPLIT_ABOVE));

   always_comb begin
      band = W'(1);
      for (int i = 1; i < POST_MAX; i++) begin
         if (over[i]) band = band + W'(1);
      end
   end
endmodule

// File: rtl/clkdiv_limit.sv
// Caps a ratio at LIMIT and reports when the cap applied.
module clkdiv_limit #(
   parameter int W     = 32,
   parameter int LIMIT = 4
) (
   input  logic [W-1:0] val,
   output logic [W-1:0] capped,
   output logic         hit
);
   assign hit    = (val > W'(LIMIT));
   assign capped = hit ? W'(LIMIT) : val;
endmodule

// File: rtl/clkdiv_solver.sv
module clkdiv_solver
   import clkdiv_pkg::*;
#(
   parameter  int RATE_W      = 32,
   parameter  int PRE_MAX     = 32,
   parameter  int POST_MAX    = 4,
   parameter  int SPLIT_SEL   = 3,
   parameter  int SPLIT_ABOVE = 4,
   localparam int PRE_W       = $clog2(PRE_MAX),
   localparam int POST_W      = $clog2(POST_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RATE_W-1:0] src_rate,
   input  logic [RATE_W-1:0] tgt_rate,
   input  logic [1:0]        src_idx,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              sat,
   output logic [PRE_W-1:0]  pre_field,
   output logic [POST_W-1:0] post_field,
   output logic [RATE_W-1:0] got_rate
);
   if (POST_MAX < 2) begin : g_bad_post
      $error("POST_MAX must be at least 2");
   end
   if (PRE_MAX < 2) begin : g_bad_pre
      $error("PRE_MAX must be at least 2");
   end
   if (SPLIT_SEL > 3 || SPLIT_SEL < 0) begin : g_bad_sel
      $error("SPLIT_SEL must fit the two-bit index");
   end
   if (RATE_W < 8 || (PRE_MAX * POST_MAX) >= (1 << (RATE_W - 1))) begin : g_bad_w
      $error("RATE_W too narrow for the ratio limits");
   end

   solve_st_e         state;
   logic [RATE_W-1:0] lat_src;
   logic [1:0]        lat_idx;
   logic [RATE_W-1:0] pre_r, post_r;
   logic              sat_r;

   logic              go_r;
   logic [RATE_W-1:0] num_r, den_r;
   logic [RATE_W-1:0] quo, rem;
   logic              fin;

   logic [RATE_W-1:0] ceil_q, tot_c, tgt_clamped;
   logic              split_en;
   logic [RATE_W-1:0] band;
   logic [RATE_W-1:0] post_cap, pre_cap;
   logic              post_hit, pre_hit;

   clkdiv_divu #(.W(RATE_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go_r),
      .num  (num_r),
      .den  (den_r),
      .quo  (quo),
      .rem  (rem),
      .fin  (fin)
   );

   assign ceil_q = quo + RATE_W'(rem != '0);
   assign tot_c  = (ceil_q == '0) ? RATE_W'(1) : ceil_q;

   clkdiv_split #(
      .W          (RATE_W),
      .PRE_MAX    (PRE_MAX),
      .POST_MAX   (POST_MAX),
      .SPLIT_SEL  (SPLIT_SEL),
      .SPLIT_ABOVE(SPLIT_ABOVE)
   ) u_split (
      .ratio   (tot_c),
      .sel     (lat_idx),
      .split_en(split_en),
      .band    (band)
   );

   clkdiv_limit #(.W(RATE_W), .LIMIT(POST_MAX)) u_post_lim (
      .val   (tot_c),
      .capped(post_cap),
      .hit   (post_hit)
   );

   clkdiv_limit #(.W(RATE_W), .LIMIT(PRE_MAX)) u_pre_lim (
      .val   (ceil_q),
      .capped(pre_cap),
      .hit   (pre_hit)
   );

   assign tgt_clamped = (src_rate != '0 && tgt_rate > src_rate) ? src_rate : tgt_rate;
   assign busy        = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         lat_src    <= '0;
         lat_idx    <= '0;
         pre_r      <= '0;
         post_r     <= '0;
         sat_r      <= 1'b0;
         go_r       <= 1'b0;
         num_r      <= '0;
         den_r      <= '0;
         done       <= 1'b0;
         err        <= 1'b0;
         sat        <= 1'b0;
         pre_field  <= '0;
         post_field <= '0;
         got_rate   <= '0;
      end else begin
         go_r <= 1'b0;
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  lat_src <= src_rate;
                  lat_idx <= src_idx;
                  if (tgt_rate == '0) begin
                     state <= ST_ERR;
                  end else begin
                     num_r <= src_rate;
                     den_r <= tgt_clamped;
                     go_r  <= 1'b1;
                     state <= ST_TOT;
                  end
               end
            end
            ST_ERR: begin
               done  <= 1'b1;
               err   <= 1'b1;
               sat   <= 1'b0;
               state <= ST_IDLE;
            end
            ST_TOT: begin
               if (fin) begin
                  go_r <= 1'b1;
                  if (split_en) begin
                     post_r <= band;
                     sat_r  <= 1'b0;
                     num_r  <= tot_c;
                     den_r  <= band;
                     state  <= ST_PRE;
                  end else begin
                     pre_r  <= RATE_W'(1);
                     post_r <= post_cap;
                     sat_r  <= post_hit;
                     num_r  <= lat_src;
                     den_r  <= RATE_W'(1);
                     state  <= ST_RT1;
                  end
               end
            end
            ST_PRE: begin
               if (fin) begin
                  pre_r <= pre_cap;
                  sat_r <= pre_hit;
                  num_r <= lat_src;
                  den_r <= pre_cap;
                  go_r  <= 1'b1;
                  state <= ST_RT1;
               end
            end
            ST_RT1: begin
               if (fin) begin
                  num_r <= quo;
                  den_r <= post_r;
                  go_r  <= 1'b1;
                  state <= ST_RT2;
               end
            end
            ST_RT2: begin
               if (fin) begin
                  got_rate   <= quo;
                  pre_field  <= PRE_W'(pre_r - RATE_W'(1));
                  post_field <= POST_W'(post_r - RATE_W'(1));
                  sat        <= sat_r;
                  err        <= 1'b0;
                  done       <= 1'b1;
                  state      <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/clkdiv_solver_chk.sv
module clkdiv_solver_chk #(
   parameter int RATE_W   = 32,
   parameter int PRE_W    = 5,
   parameter int POST_W   = 2,
   parameter int PRE_MAX  = 32,
   parameter int POST_MAX = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              sat,
   input logic [PRE_W-1:0]  pre_field,
   input logic [POST_W-1:0] post_field,
   input logic [RATE_W-1:0] got_rate
);
   // R10: completion is a single-cycle pulse
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: outputs only move with done
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(got_rate) && $stable(pre_field) && $stable(post_field)
                 && $stable(err) && $stable(sat)));

   // R11: done is only raised from the idle state
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: an accepted start makes the block busy
   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R9: a zero target leaves the result untouched
   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> ($stable(got_rate) && $stable(pre_field)
                         && $stable(post_field) && !sat));

   // R8: a saturated result sits at one of the caps
   p_sat_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sat && !err) |-> (post_field == POST_W'(POST_MAX - 1)
                                 || pre_field == PRE_W'(PRE_MAX - 1)));
endmodule

bind clkdiv_solver clkdiv_solver_chk #(
   .RATE_W  (RATE_W),
   .PRE_W   (PRE_W),
   .POST_W  (POST_W),
   .PRE_MAX (PRE_MAX),
   .POST_MAX(POST_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .sat       (sat),
   .pre_field (pre_field),
   .post_field(post_field),
   .got_rate  (got_rate)
);

// File: tb/clkdiv_solver_test.sv
`timescale 1ns/1ps
module clkdiv_solver_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] src_rate = '0;
   logic [31:0] tgt_rate = '0;
   logic [1:0]  src_idx = '0;
   logic        busy, done, err, sat;
   logic [4:0]  pre_field;
   logic [1:0]  post_field;
   logic [31:0] got_rate;

   always #5 clk = ~clk;

   clkdiv_solver uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_rate(src_rate), .tgt_rate(tgt_rate), .src_idx(src_idx),
      .busy(busy), .done(done), .err(err), .sat(sat),
      .pre_field(pre_field), .post_field(post_field), .got_rate(got_rate)
   );

   typedef struct {
      longint rate;
      int     pre;
      int     post;
      bit     is_err;
      bit     is_sat;
      string  tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t held;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   prev_done = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic exp_t model(input longint p, input longint r, input int idx, input string tag);
      exp_t   e;
      longint rr, tot, k, pre, post;
      e.tag = tag; e.is_err = 0; e.is_sat = 0; e.rate = 0; e.pre = 0; e.post = 0;
      if (r == 0) begin
         e.is_err = 1;
         return e;
      end
      rr  = (p != 0 && r > p) ? p : r;
      tot = (p + rr - 1) / rr;
      if (tot == 0) tot = 1;
      if (idx == 3 && tot > 4) begin
         k    = (tot < 32) ? 1 : (tot < 64) ? 2 : (tot < 96) ? 3 : 4;
         pre  = (tot + k - 1) / k;
         post = k;
      end else begin
         pre  = 1;
         post = tot;
      end
      if (post > 4) begin post = 4; e.is_sat = 1; end
      if (pre > 32) begin pre = 32; e.is_sat = 1; end
      e.rate = (p / pre) / post;
      e.pre  = int'(pre - 1);
      e.post = int'(post - 1);
      return e;
   endfunction

   // Reference comparison on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && prev_done) chk(0, "R10 done longer than one cycle", 1, 0);
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(0, "R10 done without accepted start", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (e.is_err) begin
                  held.is_err = 1;
                  held.is_sat = 0;
                  held.tag    = e.tag;
               end else begin
                  held = e;
               end
               chk(got_rate == held.rate[31:0], {held.tag, " rate"}, got_rate, held.rate);
               chk(pre_field == held.pre[4:0], {held.tag, " pre field"}, pre_field, held.pre);
               chk(post_field == held.post[1:0], {held.tag, " post field"}, post_field, held.post);
               chk(err == held.is_err, {held.tag, " err"}, err, held.is_err);
               chk(sat == held.is_sat, {held.tag, " sat"}, sat, held.is_sat);
            end
         end else begin
            chk(got_rate == held.rate[31:0] && pre_field == held.pre[4:0]
                && post_field == held.post[1:0] && err == held.is_err && sat == held.is_sat,
                "R10 outputs moved without done", got_rate, held.rate);
         end
         prev_done = done;
      end
   end

   task automatic issue(input longint p, input longint r, input int idx, input string tag);
      src_rate = p[31:0];
      tgt_rate = r[31:0];
      src_idx  = idx[1:0];
      start    = 1'b1;
      exp_q.push_back(model(p, r, idx, tag));
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!done && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      if (!done) chk(0, "R10 no done within limit", 0, 1);
   endtask

   task automatic run(input longint p, input longint r, input int idx, input string tag);
      issue(p, r, idx, tag);
      wait_done();
      @(negedge clk);
   endtask

   initial begin
      held.rate = 0; held.pre = 0; held.post = 0; held.is_err = 0; held.is_sat = 0; held.tag = "R13";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13: reset state
      chk(got_rate == 0 && pre_field == 0 && post_field == 0, "R13 reset fields", got_rate, 0);
      chk(!busy && !done && !err && !sat, "R13 reset flags", {busy, done, err, sat}, 0);

      run(24000000, 48000000, 0, "R1");
      run(100, 30, 0, "R2");
      run(400, 100, 3, "R3");
      run(1000, 100, 0, "R8");
      run(1000, 100, 3, "R4");
      run(4000, 100, 3, "R5");
      run(7000, 100, 3, "R5_R7");
      run(10000, 100, 3, "R6");
      run(1000000, 1000, 3, "R8");
      run(1000003, 7, 3, "R7");
      run(0, 5, 3, "R12");
      run(64'hFFFFFFFF, 1, 2, "R8");
      run(5000, 0, 3, "R9");

      // R10: start while busy is ignored
      issue(9000, 100, 3, "R10");
      repeat (8) @(negedge clk);
      src_rate = 32'd77; tgt_rate = 32'd3; src_idx = 2'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy during run", busy, 1);
      wait_done();
      @(negedge clk);

      // R11: start in the done cycle
      issue(3300, 100, 3, "R11");
      wait_done();
      issue(6500, 100, 0, "R11");
      wait_done();
      issue(0, 0, 1, "R9");
      wait_done();
      issue(999, 1000, 3, "R1");
      wait_done();
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R10 pending results", exp_q.size(), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1500000;
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule